// File: doc/BRIEF.md
# Drop Bus Integrity Monitor

This block watches one byte-parallel SDH/SONET drop bus. It reports whether the bus can be trusted before any downstream framing or pointer logic uses it. On each rising edge of the bus byte clock it captures the data byte, the frame/payload marker lead, the payload-envelope lead and the parity lead. It checks parity with a programmable sense and coverage and counts the errors in a saturating counter. A companion timing block supplies strobes that mark the overhead byte positions used for upstream AIS detection. With these strobes the block decides, frame by frame, whether the selected bytes carry an all-ones pattern.

Everything runs on a free-running reference clock. The bus clock is treated as a sampled signal. Its rising edges are found after a synchroniser, and a data pipeline of the same depth keeps each byte aligned with its edge. The same edge detector drives a loss-of-clock watchdog. Three alarm conditions (parity error, clock loss declared, AIS declared) set sticky bits. A write-one-to-clear strobe clears them. Any sticky bit that is not masked raises the interrupt request. The bus byte rate is 19.44 MB/s or 6.48 MB/s depending on the line mode. The reference clock must run at least twice the bus byte rate.

A bus rising edge affects the registered outputs at the third reference edge after the rising edge is first sampled. Two reference cycles go to the synchroniser and one to the update.

The clock watchdog is a state machine with states CLK_OK, CLK_LOST and CLK_REGAIN. It has these transitions:
- CLK_OK to CLK_LOST on a gap timeout.
- CLK_LOST to CLK_REGAIN on the first edge.
- CLK_REGAIN to CLK_OK on the fourth consecutive edge.
- CLK_REGAIN back to CLK_LOST on a timeout.

The AIS monitor is a state machine with states AIS_NORMAL, AIS_ENTER, AIS_ACTIVE and AIS_LEAVE. It moves only at a frame boundary:
- AIS_NORMAL to AIS_ENTER on an all-ones frame.
- AIS_ENTER to AIS_ACTIVE on the third consecutive all-ones frame.
- AIS_ENTER back to AIS_NORMAL on any other frame.
- AIS_ACTIVE to AIS_LEAVE on a frame that is not all-ones.
- AIS_LEAVE to AIS_NORMAL on the third consecutive such frame.
- AIS_LEAVE back to AIS_ACTIVE on an all-ones frame.

Top module: `dbm_drop_mon`

## Requirements
- R1: After reset, `perr_cnt` is 0, `loc_alarm`, `ais_alarm` and `irq` are 0, and `sticky` is 3'b000.
- R2: With `cfg_even`=0 and `cfg_data_only`=0, a bus byte is in error when the XOR of the 8 data bits, marker, SPE and parity leads is 0 (odd parity over ten leads). Each erroneous byte adds one to `perr_cnt`, and a good byte adds nothing.
- R3: With `cfg_even`=1, the sense is inverted: a byte is in error when that XOR is 1.
- R4: With `cfg_data_only`=1, only the 8 data bits and the parity lead enter the check, and the marker and SPE leads have no effect on the result.
- R5: `perr_cnt` is 16 bits wide and holds at 16'hFFFF under further errors.
- R6: A one-cycle `cnt_rd` pulse sets `perr_cnt` to 0. If an error byte is counted in the same cycle, the result is 1.
- R7: `loc_alarm` rises when no bus clock rising edge has been found for 16 reference clock cycles.
- R8: `loc_alarm` falls on the fourth consecutive bus clock edge in which no 16-cycle gap occurs. A gap during recovery restarts the count.
- R9: `ais_alarm` rises after 3 consecutive frames in which every selected byte was 8'hFF and at least one selected byte occurred. Bytes flagged by `toh_e1_stb` are selected when `cfg_ais_ptr`=0, and bytes flagged by `ptr_stb` when `cfg_ais_ptr`=1. A frame ends on the byte flagged by `frame_stb`.
- R10: `ais_alarm` falls after 3 consecutive frames that do not meet the all-ones condition, and an all-ones frame in between restarts that count.
- R11: `sticky` bit 0 is set by a parity error byte, bit 1 when `loc_alarm` is declared and bit 2 when `ais_alarm` is declared. A 1 on the matching bit of `sts_clr` clears the bit, and a set in the same cycle takes priority over the clear.
- R12: `irq` is 1 exactly when some bit of `sticky` is 1 whose `irq_mask` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk | input | 1 | Drop bus byte clock (sampled) |
| bus_data | input | 8 | Drop bus data byte |
| bus_c1j1v1 | input | 1 | Frame/payload marker lead |
| bus_spe | input | 1 | Payload-envelope indicator lead |
| bus_par | input | 1 | Parity lead |
| toh_e1_stb | input | 1 | Marks the overhead E1 byte position |
| ptr_stb | input | 1 | Marks the H1/H2 pointer byte positions |
| frame_stb | input | 1 | Marks the last byte of a frame |
| cfg_even | input | 1 | 1 selects even parity sense |
| cfg_data_only | input | 1 | 1 restricts parity to the data byte |
| cfg_ais_ptr | input | 1 | 1 selects pointer bytes for AIS, 0 the E1 byte |
| irq_mask | input | 3 | Per-alarm interrupt mask, 1 masks |
| sts_clr | input | 3 | Write-one-to-clear for sticky bits |
| cnt_rd | input | 1 | Counter read strobe, clears the counter |
| perr_cnt | output | 16 | Saturating parity error count |
| loc_alarm | output | 1 | Bus clock lost |
| ais_alarm | output | 1 | Upstream AIS present |
| sticky | output | 3 | Sticky alarms {AIS, LOC, parity} |
| irq | output | 1 | Interrupt request |

## Verification
A wrong gap or regain count in the clock watchdog moves the rising or falling edge of `loc_alarm` by whole reference cycles. This shows within 16 cycles of the bus clock stopping or within four bus bytes of it restarting. A corrupted AIS frame counter or accumulator shifts `ais_alarm` by a whole frame, so it appears at the next `frame_stb` byte plus three reference cycles. A parity sense or coverage fault shows in `perr_cnt` three reference cycles after the offending bus edge. A stuck sticky or mask path shows on `irq` in the same cycle that `sticky` or `irq_mask` changes. The bench's reference model predicts every output on every clock, so any of these faults is caught at the first cycle where it changes a port.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

    typedef enum logic [1:0] {
        CLK_OK,
        CLK_LOST,
        CLK_REGAIN
    } clk_st_e;

    typedef enum logic [1:0] {
        AIS_NORMAL,
        AIS_ENTER,
        AIS_ACTIVE,
        AIS_LEAVE
    } ais_st_e;

    typedef struct packed {
        logic [7:0] data;
        logic       mark;
        logic       spe;
        logic       par;
        logic       toh;
        logic       ptr;
        logic       frm;
    } bus_byte_t;

    localparam int unsigned ALM_PAR = 0;
    localparam int unsigned ALM_LOC = 1;
    localparam int unsigned ALM_AIS = 2;
    localparam int unsigned ALM_N   = 3;

endpackage

// File: rtl/dbm_bus_sampler.sv
module dbm_bus_sampler
    import dbm_pkg::*;
#(
    parameter int unsigned SYNC_N = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bus_clk,
    input  bus_byte_t bus_in,
    output logic      byte_evt,
    output bus_byte_t byte_out
);

    // sync_q[k] holds the bus clock level k+1 reference edges ago
    logic [SYNC_N:0] sync_q;
    bus_byte_t       pipe_q [SYNC_N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            for (int i = 0; i < SYNC_N; i++) begin
                pipe_q[i] <= '0;
            end
        end else begin
            sync_q    <= {sync_q[SYNC_N-1:0], bus_clk};
            pipe_q[0] <= bus_in;
            for (int i = 1; i < SYNC_N; i++) begin
                pipe_q[i] <= pipe_q[i-1];
            end
        end
    end

    // data pipe has the same depth as the synchroniser, so the byte lines up with its edge
    assign byte_evt = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];
    assign byte_out = pipe_q[SYNC_N-1];

endmodule

// File: rtl/dbm_parity.sv
module dbm_parity #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_evt,
    input  logic [7:0]       data,
    input  logic             mark,
    input  logic             spe,
    input  logic             par,
    input  logic             cfg_even,
    input  logic             cfg_data_only,
    input  logic             cnt_rd,
    output logic             err_evt,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic covered;
    logic lead_sum;

    always_comb begin
        covered  = cfg_data_only ? (^data) : (^{data, mark, spe});
        lead_sum = covered ^ par;
        err_evt  = byte_evt & (cfg_even ? lead_sum : ~lead_sum);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt_rd) begin
            cnt <= err_evt ? CNT_W'(1) : '0;
        end else if (err_evt && cnt != CNT_MAX) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/dbm_clk_loss.sv
module dbm_clk_loss
    import dbm_pkg::*;
#(
    parameter int unsigned GAP_LIMIT    = 16,
    parameter int unsigned REGAIN_EDGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_evt,
    output logic loc,
    output logic declare
);

    localparam int unsigned GW = $clog2(GAP_LIMIT);
    localparam int unsigned RW = $clog2(REGAIN_EDGES + 1);

    logic [GW-1:0] gap_q;
    logic [RW-1:0] run_q, run_d;
    clk_st_e       st_q, st_d;
    logic          timeout;

    assign timeout = !edge_evt && (gap_q == GW'(GAP_LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (edge_evt || timeout) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + GW'(1);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CLK_OK;
            run_q <= '0;
        end else begin
            st_q  <= st_d;
            run_q <= run_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        run_d = run_q;
        unique case (st_q)
            CLK_OK: begin
                if (timeout) st_d = CLK_LOST;
            end
            CLK_LOST: begin
                if (edge_evt) begin
                    st_d  = CLK_REGAIN;
                    run_d = RW'(1);
                end
            end
            CLK_REGAIN: begin
                if (timeout) begin
                    st_d  = CLK_LOST;
                    run_d = '0;
                end else if (edge_evt) begin
                    if (run_q == RW'(REGAIN_EDGES - 1)) begin
                        st_d  = CLK_OK;
                        run_d = '0;
                    end else begin
                        run_d = run_q + RW'(1);
                    end
                end
            end
            default: begin
                st_d  = CLK_OK;
                run_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        loc     = (st_q != CLK_OK);
        declare = (st_q == CLK_OK) && timeout;
    end

endmodule

// File: rtl/dbm_ais_mon.sv
module dbm_ais_mon
    import dbm_pkg::*;
#(
    parameter int unsigned AIS_FRAMES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_evt,
    input  logic       frame_evt,
    input  logic [7:0] data,
    input  logic       toh_stb,
    input  logic       ptr_stb,
    input  logic       cfg_sel_ptr,
    output logic       ais,
    output logic       declare
);

    localparam int unsigned FW = $clog2(AIS_FRAMES + 1);

    logic          seen_q, ones_q;
    logic          sel, verdict;
    logic [FW-1:0] run_q, run_d;
    ais_st_e       st_q, st_d;

    assign sel     = cfg_sel_ptr ? ptr_stb : toh_stb;
    assign verdict = seen_q & ones_q;

    // per-frame accumulator over the selected byte positions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            ones_q <= 1'b1;
        end else if (frame_evt) begin
            seen_q <= 1'b0;
            ones_q <= 1'b1;
        end else if (byte_evt && sel) begin
            seen_q <= 1'b1;
            if (data != 8'hFF) ones_q <= 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= AIS_NORMAL;
            run_q <= '0;
        end else begin
            st_q  <= st_d;
            run_q <= run_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        run_d = run_q;
        if (frame_evt) begin
            unique case (st_q)
                AIS_NORMAL: begin
                    if (verdict) begin
                        st_d  = AIS_ENTER;
                        run_d = FW'(1);
                    end
                end
                AIS_ENTER: begin
                    if (!verdict) begin
                        st_d  = AIS_NORMAL;
                        run_d = '0;
                    end else if (run_q == FW'(AIS_FRAMES - 1)) begin
                        st_d  = AIS_ACTIVE;
                        run_d = '0;
                    end else begin
                        run_d = run_q + FW'(1);
                    end
                end
                AIS_ACTIVE: begin
                    if (!verdict) begin
                        st_d  = AIS_LEAVE;
                        run_d = FW'(1);
                    end
                end
                AIS_LEAVE: begin
                    if (verdict) begin
                        st_d  = AIS_ACTIVE;
                        run_d = '0;
                    end else if (run_q == FW'(AIS_FRAMES - 1)) begin
                        st_d  = AIS_NORMAL;
                        run_d = '0;
                    end else begin
                        run_d = run_q + FW'(1);
                    end
                end
                default: begin
                    st_d  = AIS_NORMAL;
                    run_d = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        ais     = (st_q == AIS_ACTIVE) || (st_q == AIS_LEAVE);
        declare = (st_q == AIS_ENTER) && (st_d == AIS_ACTIVE);
    end

endmodule

// File: rtl/dbm_drop_mon.sv
module dbm_drop_mon
    import dbm_pkg::*;
#(
    parameter int unsigned CNT_W        = 16,
    parameter int unsigned SYNC_N       = 2,
    parameter int unsigned GAP_LIMIT    = 16,
    parameter int unsigned REGAIN_EDGES = 4,
    parameter int unsigned AIS_FRAMES   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_clk,
    input  logic [7:0]       bus_data,
    input  logic             bus_c1j1v1,
    input  logic             bus_spe,
    input  logic             bus_par,
    input  logic             toh_e1_stb,
    input  logic             ptr_stb,
    input  logic             frame_stb,
    input  logic             cfg_even,
    input  logic             cfg_data_only,
    input  logic             cfg_ais_ptr,
    input  logic [2:0]       irq_mask,
    input  logic [2:0]       sts_clr,
    input  logic             cnt_rd,
    output logic [CNT_W-1:0] perr_cnt,
    output logic             loc_alarm,
    output logic             ais_alarm,
    output logic [2:0]       sticky,
    output logic             irq
);

    bus_byte_t        bus_in, smp;
    logic             byte_evt, frame_evt;
    logic             par_err, loc_decl, ais_decl;
    logic [ALM_N-1:0] set_vec;

    assign bus_in = '{data: bus_data, mark: bus_c1j1v1, spe: bus_spe, par: bus_par,
                      toh: toh_e1_stb, ptr: ptr_stb, frm: frame_stb};

    dbm_bus_sampler #(.SYNC_N(SYNC_N)) u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_clk  (bus_clk),
        .bus_in   (bus_in),
        .byte_evt (byte_evt),
        .byte_out (smp)
    );

    assign frame_evt = byte_evt & smp.frm;

    dbm_parity #(.CNT_W(CNT_W)) u_par (
        .clk           (clk),
        .rst_n         (rst_n),
        .byte_evt      (byte_evt),
        .data          (smp.data),
        .mark          (smp.mark),
        .spe           (smp.spe),
        .par           (smp.par),
        .cfg_even      (cfg_even),
        .cfg_data_only (cfg_data_only),
        .cnt_rd        (cnt_rd),
        .err_evt       (par_err),
        .cnt           (perr_cnt)
    );

    dbm_clk_loss #(.GAP_LIMIT(GAP_LIMIT), .REGAIN_EDGES(REGAIN_EDGES)) u_loc (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_evt (byte_evt),
        .loc      (loc_alarm),
        .declare  (loc_decl)
    );

    dbm_ais_mon #(.AIS_FRAMES(AIS_FRAMES)) u_ais (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_evt    (byte_evt),
        .frame_evt   (frame_evt),
        .data        (smp.data),
        .toh_stb     (smp.toh),
        .ptr_stb     (smp.ptr),
        .cfg_sel_ptr (cfg_ais_ptr),
        .ais         (ais_alarm),
        .declare     (ais_decl)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[ALM_PAR] = par_err;
        set_vec[ALM_LOC] = loc_decl;
        set_vec[ALM_AIS] = ais_decl;
    end

    // set beats clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky <= '0;
        end else begin
            sticky <= (sticky & ~sts_clr) | set_vec;
        end
    end

    assign irq = |(sticky & ~irq_mask);

endmodule

// File: rtl/dbm_drop_mon_chk.sv
module dbm_drop_mon_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_rd,
    input logic [2:0]       sts_clr,
    input logic [CNT_W-1:0] perr_cnt,
    input logic             loc_alarm,
    input logic             ais_alarm,
    input logic [2:0]       sticky,
    input logic             byte_evt,
    input logic             frame_evt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_cnt == CNT_MAX && !cnt_rd) |=> (perr_cnt == CNT_MAX));

    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_rd && perr_cnt != CNT_MAX) |=>
            (perr_cnt == $past(perr_cnt) || perr_cnt == $past(perr_cnt) + CNT_W'(1)));

    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rd |=> (perr_cnt <= CNT_W'(1)));

    a_r11_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sticky & ~sts_clr)) |=>
            ((sticky & $past(sticky & ~sts_clr)) == $past(sticky & ~sts_clr)));

    a_r7_loc_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loc_alarm) |-> sticky[1]);

    a_r8_loc_clear_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(loc_alarm) |-> $past(byte_evt));

    a_r9_ais_moves_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ais_alarm) |-> $past(frame_evt));

    a_r9_ais_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ais_alarm) |-> sticky[2]);

endmodule

bind dbm_drop_mon dbm_drop_mon_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_rd    (cnt_rd),
    .sts_clr   (sts_clr),
    .perr_cnt  (perr_cnt),
    .loc_alarm (loc_alarm),
    .ais_alarm (ais_alarm),
    .sticky    (sticky),
    .byte_evt  (byte_evt),
    .frame_evt (frame_evt)
);

// File: tb/sim_dbm_drop_mon.sv
module sim_dbm_drop_mon;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_clk = 1'b0;
    logic [7:0]  bus_data = '0;
    logic        bus_c1j1v1 = 1'b0, bus_spe = 1'b0, bus_par = 1'b0;
    logic        toh_e1_stb = 1'b0, ptr_stb = 1'b0, frame_stb = 1'b0;
    logic        cfg_even = 1'b0, cfg_data_only = 1'b0, cfg_ais_ptr = 1'b0;
    logic [2:0]  irq_mask = '0, sts_clr = '0;
    logic        cnt_rd = 1'b0;
    logic [15:0] perr_cnt;
    logic        loc_alarm, ais_alarm, irq;
    logic [2:0]  sticky;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    dbm_drop_mon u0 (
        .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_data(bus_data),
        .bus_c1j1v1(bus_c1j1v1), .bus_spe(bus_spe), .bus_par(bus_par),
        .toh_e1_stb(toh_e1_stb), .ptr_stb(ptr_stb), .frame_stb(frame_stb),
        .cfg_even(cfg_even), .cfg_data_only(cfg_data_only), .cfg_ais_ptr(cfg_ais_ptr),
        .irq_mask(irq_mask), .sts_clr(sts_clr), .cnt_rd(cnt_rd),
        .perr_cnt(perr_cnt), .loc_alarm(loc_alarm), .ais_alarm(ais_alarm),
        .sticky(sticky), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // bus samples at each reference edge; an edge seen two samples back is acted on now
    logic [14:0] h0, h1, h2, h3;
    int          m_cnt, m_gap, m_cst, m_crun, m_ast, m_arun;
    bit          m_seen, m_ones;
    logic [2:0]  m_sticky;

    always @(posedge clk) begin
        bit evt, to, sel, v, perr;
        logic [7:0] d;
        logic [2:0] setv;
        if (!rst_n) begin
            h0 = '0; h1 = '0; h2 = '0; h3 = '0;
            m_cnt = 0; m_gap = 0; m_cst = 0; m_crun = 0; m_ast = 0; m_arun = 0;
            m_seen = 0; m_ones = 1; m_sticky = '0;
        end else begin
            h3 = h2; h2 = h1; h1 = h0;
            h0 = {bus_clk, bus_data, bus_c1j1v1, bus_spe, bus_par, toh_e1_stb, ptr_stb, frame_stb};
            evt = h2[14] && !h3[14];
            d = h2[13:6];
            setv = '0;
            // parity: R2 R3 R4
            perr = 0;
            if (evt) begin
                logic cov;
                cov = cfg_data_only ? (^d) : (^{d, h2[5], h2[4]});
                perr = cfg_even ? (cov ^ h2[3]) : !(cov ^ h2[3]);
            end
            if (cnt_rd) m_cnt = perr ? 1 : 0;
            else if (perr && m_cnt < 65535) m_cnt++;
            setv[0] = perr;
            // clock loss: R7 R8
            to = !evt && (m_gap == 15);
            m_gap = (evt || to) ? 0 : m_gap + 1;
            case (m_cst)
                0: if (to) begin m_cst = 1; setv[1] = 1; end
                1: if (evt) begin m_cst = 2; m_crun = 1; end
                default: begin
                    if (to) begin m_cst = 1; m_crun = 0; end
                    else if (evt) begin
                        if (m_crun == 3) begin m_cst = 0; m_crun = 0; end
                        else m_crun++;
                    end
                end
            endcase
            // AIS: R9 R10
            if (evt) begin
                sel = cfg_ais_ptr ? h2[1] : h2[2];
                if (h2[0]) begin
                    v = m_seen && m_ones;
                    m_seen = 0; m_ones = 1;
                    case (m_ast)
                        0: if (v) begin m_ast = 1; m_arun = 1; end
                        1: if (!v) m_ast = 0;
                           else if (m_arun == 2) begin m_ast = 2; setv[2] = 1; end
                           else m_arun++;
                        2: if (!v) begin m_ast = 3; m_arun = 1; end
                        default: if (v) m_ast = 2;
                                 else if (m_arun == 2) m_ast = 0;
                                 else m_arun++;
                    endcase
                end else if (sel) begin
                    m_seen = 1;
                    if (d != 8'hFF) m_ones = 0;
                end
            end
            m_sticky = (m_sticky & ~sts_clr) | setv;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2,R5,R6", "perr_cnt", {16'h0, perr_cnt}, m_cnt);
            chk("R7,R8", "loc_alarm", {31'h0, loc_alarm}, {31'h0, m_cst != 0});
            chk("R9,R10", "ais_alarm", {31'h0, ais_alarm}, {31'h0, m_ast >= 2});
            chk("R11", "sticky", {29'h0, sticky}, {29'h0, m_sticky});
            chk("R12", "irq", {31'h0, irq}, {31'h0, |(m_sticky & ~irq_mask)});
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic good_par(input logic [7:0] d, input logic m, input logic s);
        logic cov;
        cov = cfg_data_only ? (^d) : (^{d, m, s});
        return cfg_even ? cov : ~cov;
    endfunction

    task automatic put_byte(input logic [7:0] d, input logic m, input logic s, input logic p,
                            input logic t, input logic pt, input logic f, input int hold);
        bus_data = d; bus_c1j1v1 = m; bus_spe = s; bus_par = p;
        toh_e1_stb = t; ptr_stb = pt; frame_stb = f;
        bus_clk = 1'b1;
        repeat (hold) @(negedge clk);
        bus_clk = 1'b0;
        repeat (hold) @(negedge clk);
    endtask

    task automatic good_byte(input logic [7:0] d, input logic m, input logic s);
        put_byte(d, m, s, good_par(d, m, s), 0, 0, 0, 2);
    endtask

    task automatic bad_byte(input logic [7:0] d, input logic m, input logic s, input int hold);
        put_byte(d, m, s, ~good_par(d, m, s), 0, 0, 0, hold);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_rd();
        cnt_rd = 1'b1; @(negedge clk); cnt_rd = 1'b0;
    endtask

    task automatic pulse_clr(input logic [2:0] v);
        sts_clr = v; @(negedge clk); sts_clr = '0;
    endtask

    task automatic frame(input logic [7:0] tv, input logic [7:0] pv);
        put_byte(tv, 0, 0, good_par(tv, 0, 0), 1, 0, 0, 2);
        put_byte(pv, 0, 1, good_par(pv, 0, 1), 0, 1, 0, 2);
        put_byte(pv, 0, 1, good_par(pv, 0, 1), 0, 1, 0, 2);
        put_byte(8'h55, 0, 1, good_par(8'h55, 0, 1), 0, 0, 0, 2);
        put_byte(8'h00, 1, 0, good_par(8'h00, 1, 0), 0, 0, 1, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1", "perr_cnt", {16'h0, perr_cnt}, 0);
        chk("R1", "alarms", {30'h0, loc_alarm, ais_alarm}, 0);
        chk("R1", "sticky/irq", {28'h0, sticky, irq}, 0);

        // R2 odd over ten leads
        good_byte(8'h00, 0, 0); good_byte(8'hA5, 1, 0);
        good_byte(8'h3C, 0, 1); good_byte(8'hFF, 1, 1);
        settle();
        chk("R2", "good bytes count", {16'h0, perr_cnt}, 0);
        bad_byte(8'h01, 1, 0, 2); bad_byte(8'h7E, 0, 1, 2);
        // marker counted under default coverage: parity over data only, marker set
        put_byte(8'h00, 1, 0, 1'b1, 0, 0, 0, 2);
        settle();
        chk("R2", "bad bytes count", {16'h0, perr_cnt}, 3);
        chk("R11", "parity sticky", {31'h0, sticky[0]}, 1);
        chk("R12", "irq unmasked", {31'h0, irq}, 1);

        // R6 read clears, R11 clear
        pulse_rd();
        chk("R6", "cleared by read", {16'h0, perr_cnt}, 0);
        pulse_clr(3'b001);
        chk("R11", "sticky cleared", {29'h0, sticky}, 0);
        chk("R12", "irq after clear", {31'h0, irq}, 0);

        // R3 even sense
        cfg_even = 1'b1;
        good_byte(8'h12, 0, 1); good_byte(8'hF0, 1, 1);
        settle();
        chk("R3", "even good", {16'h0, perr_cnt}, 0);
        bad_byte(8'h12, 0, 1, 2); bad_byte(8'h80, 0, 0, 2);
        settle();
        chk("R3", "even bad", {16'h0, perr_cnt}, 2);
        cfg_even = 1'b0;
        pulse_rd();

        // R4 data-only coverage: marker and SPE have no effect
        cfg_data_only = 1'b1;
        put_byte(8'h03, 1, 0, ~(^8'h03), 0, 0, 0, 2);
        put_byte(8'h03, 0, 1, ~(^8'h03), 0, 0, 0, 2);
        put_byte(8'h81, 1, 1, ~(^8'h81), 0, 0, 0, 2);
        put_byte(8'h40, 0, 0, ~(^8'h40), 0, 0, 0, 2);
        settle();
        chk("R4", "data-only good", {16'h0, perr_cnt}, 0);
        put_byte(8'h40, 1, 1, ^8'h40, 0, 0, 0, 2);
        settle();
        chk("R4", "data-only bad", {16'h0, perr_cnt}, 1);
        cfg_data_only = 1'b0;

        // R12 masking
        irq_mask = 3'b001; @(negedge clk);
        chk("R12", "irq masked", {31'h0, irq}, 0);
        irq_mask = 3'b000; @(negedge clk);
        chk("R12", "irq unmasked again", {31'h0, irq}, 1);
        pulse_clr(3'b111); pulse_rd();

        // R9 / R10 AIS on E1 byte
        cfg_ais_ptr = 1'b0;
        frame(8'hFF, 8'h00); frame(8'hFF, 8'h00);
        settle();
        chk("R9", "two frames", {31'h0, ais_alarm}, 0);
        frame(8'hFF, 8'h00);
        settle();
        chk("R9", "three frames", {31'h0, ais_alarm}, 1);
        chk("R11", "ais sticky", {31'h0, sticky[2]}, 1);
        frame(8'h00, 8'hFF); frame(8'h00, 8'hFF);
        settle();
        chk("R10", "two clear frames", {31'h0, ais_alarm}, 1);
        frame(8'h00, 8'hFF);
        settle();
        chk("R10", "three clear frames", {31'h0, ais_alarm}, 0);
        // R9 pointer bytes selected
        cfg_ais_ptr = 1'b1;
        frame(8'hFF, 8'h00); frame(8'hFF, 8'h00); frame(8'hFF, 8'h00);
        settle();
        chk("R9", "E1 ignored when pointer selected", {31'h0, ais_alarm}, 0);
        frame(8'h00, 8'hFF); frame(8'h00, 8'hFF); frame(8'h00, 8'hFF);
        settle();
        chk("R9", "pointer all-ones", {31'h0, ais_alarm}, 1);
        frame(8'h00, 8'h7F); frame(8'h00, 8'hFF);
        frame(8'h00, 8'h00); frame(8'h00, 8'h00);
        settle();
        chk("R10", "restart on all-ones", {31'h0, ais_alarm}, 1);
        frame(8'h00, 8'h00);
        settle();
        chk("R10", "cleared", {31'h0, ais_alarm}, 0);
        pulse_clr(3'b111);

        // R7 / R8 clock loss
        repeat (20) @(negedge clk);
        chk("R7", "loss declared", {31'h0, loc_alarm}, 1);
        chk("R11", "loc sticky", {31'h0, sticky[1]}, 1);
        good_byte(8'h11, 0, 0); good_byte(8'h22, 0, 0); good_byte(8'h33, 0, 0);
        settle();
        chk("R8", "three edges", {31'h0, loc_alarm}, 1);
        good_byte(8'h44, 0, 0);
        settle();
        chk("R8", "four edges", {31'h0, loc_alarm}, 0);
        pulse_clr(3'b111); pulse_rd();

        // R5 saturation with fast bus clock
        for (int i = 0; i < 65540; i++) bad_byte(8'h00, 0, 0, 1);
        settle();
        chk("R5", "saturated", {16'h0, perr_cnt}, 32'hFFFF);
        pulse_rd();
        chk("R6", "read after saturation", {16'h0, perr_cnt}, 0);
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule